// File: doc/BRIEF.md
# SPI Slave Register Port with Framed Header

This block lets an external SPI master read and write a byte-wide internal register array. The array sits behind a simple synchronous memory port: a write strobe with address and data, and a read strobe whose data returns on the following system clock. All SPI pins are oversampled by the system clock, and the block accepts SPI modes 0 and 3 without any configuration, since both modes sample on the rising SCLK edge.

Every transaction starts when select is pulled low. A 32-bit header follows, most significant bit first: a 16-bit start address, then an access bit (1 = write, 0 = read), then a 15-bit byte count. Data bytes then follow without any new header. A count of one is a single access. A larger count is a burst, and the address steps by one after each byte. On a read, the byte at the current address is fetched as soon as the last header bit is taken in, so it is ready for the first falling edge. Bytes clocked past the count are ignored. Raising select at any time ends the frame.

The control state machine has eight states. IDLE goes to HEADER when select is seen low. HEADER goes to WRITE (access bit 1), to FETCH (access bit 0), or to DISCARD (count 0) on the 32nd rising edge. FETCH always goes to LOAD, and LOAD goes to READ. READ goes to FETCH after each full byte, or to DISCARD after the last one. WRITE goes to COMMIT after each full byte. COMMIT goes back to WRITE, or to DISCARD after the last byte. Every state except IDLE returns to IDLE when select is seen high. The SCLK half period must be at least six system clocks.

Top module: `spi_regport`

## Requirements
- R1: Both SCLK idle levels work (mode 0 idles low, mode 3 idles high). MOSI is sampled on each rising SCLK edge, and MISO changes only after a falling SCLK edge.
- R2: The first 32 bits after select falls form the header, most significant bit first. They are a 16-bit address, then one access bit (1 = write, 0 = read), then a 15-bit byte count.
- R3: On a write, each complete 8-bit data byte (most significant bit first) gives exactly one mem_we pulse, carrying mem_addr and that byte on mem_wdata.
- R4: On a read, mem_re pulses for one cycle and mem_rdata is taken one cycle later. The byte then leaves on MISO, most significant bit first, starting at the first falling edge after the last header bit.
- R5: In a burst (count above 1), the address rises by one after every data byte and wraps from 0xFFFF to 0x0000.
- R6: While selected, spi_miso_oe is 1. spi_miso stays 0 from the moment select falls until the header ends.
- R7: spi_miso_oe is 0 during reset and whenever select is high.
- R8: Data bytes beyond the count cause no memory write and no extra fetch, and MISO reads them as 0x00.
- R9: Select rising mid-frame aborts the frame. A partial data byte is never written, and the next frame is decoded from a fresh header.
- R10: A count of 0 causes no memory access at all.
- R11: mem_we and mem_re are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| mem_addr | output | 16 | Register array byte address |
| mem_we | output | 1 | Write strobe, one cycle per byte |
| mem_re | output | 1 | Read strobe, data expected the next cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_re |

## Verification
Some properties are checked by assertions on every cycle: MISO held low in HEADER, a read strobe always followed by LOAD, the address stepping by one after each write strobe, a return to IDLE one cycle after select rises, the output enable dropping when select is high, and the two memory strobes never overlapping. Other behaviour only shows up in end-to-end frames from the bench. That covers bit ordering in both SPI modes, the exact data on MISO, burst wraparound at the top of the address space, bytes past the count being ignored, aborts in the middle of a byte or of the header, and a zero count doing nothing.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_FETCH,
        ST_LOAD,
        ST_READ,
        ST_WRITE,
        ST_COMMIT,
        ST_DISCARD
    } frame_state_e;

    localparam logic ACC_WRITE = 1'b1;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic mosi_in,
    input  logic cs_n_in,
    output logic sclk_s,
    output logic mosi_s,
    output logic cs_n_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b100;  // select idles high

    logic [NSIG-1:0] chain [STAGES];
    logic            sclk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= {cs_n_in, mosi_in, sclk_in};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= chain[STAGES-1][0];
    end

    assign sclk_s    = chain[STAGES-1][0];
    assign mosi_s    = chain[STAGES-1][1];
    assign cs_n_s    = chain[STAGES-1][2];
    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;

endmodule

// File: rtl/spi_regport_fsm.sv
module spi_regport_fsm
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              miso,
    output logic              miso_oe
);
    localparam int HDR_W = ADDR_W + 1 + LEN_W;
    localparam int HCW   = $clog2(HDR_W);
    localparam int DCW   = $clog2(DATA_W);
    localparam logic [HCW-1:0]   HDR_LAST = HCW'(HDR_W - 1);
    localparam logic [DCW-1:0]   DAT_LAST = DCW'(DATA_W - 1);
    localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

    frame_state_e state, state_nx;

    logic [HDR_W-1:0]  hdr_sr;
    logic [HDR_W-1:0]  hdr_full;
    logic [HCW-1:0]    hdr_cnt;
    logic [DCW-1:0]    dat_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] tx_sr;
    logic              miso_q;

    logic hdr_done, byte_done, last_byte;
    logic [ADDR_W-1:0] hdr_addr;
    logic              hdr_acc;
    logic [LEN_W-1:0]  hdr_len;

    assign hdr_full  = {hdr_sr[HDR_W-2:0], mosi_s};
    assign hdr_addr  = hdr_full[HDR_W-1 -: ADDR_W];
    assign hdr_acc   = hdr_full[LEN_W];
    assign hdr_len   = hdr_full[LEN_W-1:0];
    assign hdr_done  = sclk_rise && (hdr_cnt == HDR_LAST);
    assign byte_done = sclk_rise && (dat_cnt == DAT_LAST);
    assign last_byte = (rem_q == ONE_LEFT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (!cs_n_s) state_nx = ST_HEADER;
            ST_HEADER: begin
                if (cs_n_s) state_nx = ST_IDLE;
                else if (hdr_done) begin
                    if (hdr_len == '0)            state_nx = ST_DISCARD;
                    else if (hdr_acc == ACC_WRITE) state_nx = ST_WRITE;
                    else                          state_nx = ST_FETCH;
                end
            end
            ST_FETCH:   state_nx = cs_n_s ? ST_IDLE : ST_LOAD;
            ST_LOAD:    state_nx = cs_n_s ? ST_IDLE : ST_READ;
            ST_READ: begin
                if (cs_n_s) state_nx = ST_IDLE;
                else if (byte_done) state_nx = last_byte ? ST_DISCARD : ST_FETCH;
            end
            ST_WRITE: begin
                if (cs_n_s) state_nx = ST_IDLE;
                else if (byte_done) state_nx = ST_COMMIT;
            end
            ST_COMMIT: begin
                if (cs_n_s) state_nx = ST_IDLE;
                else        state_nx = last_byte ? ST_DISCARD : ST_WRITE;
            end
            ST_DISCARD: if (cs_n_s) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_re    = (state == ST_FETCH);
        mem_we    = (state == ST_COMMIT);
        miso_oe   = (state != ST_IDLE);
        mem_addr  = addr_q;
        mem_wdata = rx_sr;
        miso      = miso_q;
    end

    // header capture and bit counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_sr  <= '0;
            hdr_cnt <= '0;
            dat_cnt <= '0;
        end else if (state == ST_IDLE) begin
            hdr_cnt <= '0;
            dat_cnt <= '0;
        end else if (sclk_rise) begin
            if (state == ST_HEADER) begin
                hdr_sr  <= hdr_full;
                hdr_cnt <= hdr_cnt + 1'b1;
                dat_cnt <= '0;
            end else if (state == ST_READ || state == ST_WRITE) begin
                dat_cnt <= dat_cnt + 1'b1;
            end
        end
    end

    // address and remaining count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (state == ST_HEADER && hdr_done) begin
            addr_q <= hdr_addr;
            rem_q  <= hdr_len;
        end else if ((state == ST_READ && byte_done) || state == ST_COMMIT) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    // data shift registers and MISO
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr  <= '0;
            tx_sr  <= '0;
            miso_q <= 1'b0;
        end else begin
            if (state == ST_WRITE && sclk_rise)
                rx_sr <= {rx_sr[DATA_W-2:0], mosi_s};
            if (state == ST_LOAD)
                tx_sr <= mem_rdata;
            else if (state == ST_READ && sclk_fall)
                tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            if (state == ST_IDLE || state == ST_HEADER || state == ST_DISCARD)
                miso_q <= 1'b0;
            else if (state == ST_READ && sclk_fall)
                miso_q <= tx_sr[DATA_W-1];
        end
    end

    // R6
    hdr_miso_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HEADER) |-> !miso);

    // R4
    fetch_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !cs_n_s) |=> (state == ST_LOAD));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_s) |=> (state == ST_IDLE));

    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso_oe);

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
    parameter int ADDR_W      = 16,
    parameter int LEN_W       = 15,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic sclk_s, mosi_s, cs_n_s, sclk_rise, sclk_fall;

    spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .mosi_in   (spi_mosi),
        .cs_n_in   (spi_cs_n),
        .sclk_s    (sclk_s),
        .mosi_s    (mosi_s),
        .cs_n_s    (cs_n_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    spi_regport_fsm #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .mosi_s    (mosi_s),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
    localparam int H = 8;  // SCLK half period in system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic miso, miso_oe, mem_we, mem_re;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    always #10 clk = ~clk;  // 50 MHz

    spi_regport u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int checks = 0, errs = 0, wr_cnt = 0, re_cnt = 0;
    bit done = 0;
    logic [7:0]  ram     [logic [15:0]];
    logic [7:0]  ref_mem [logic [15:0]];
    logic [23:0] exp_q   [$];
    logic [7:0]  tx_buf  [0:15];
    logic [7:0]  rx_buf  [0:15];

    function automatic logic [7:0] init_val(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] ram_rd(logic [15:0] a);
        return ram.exists(a) ? ram[a] : init_val(a);
    endfunction
    function automatic logic [7:0] ref_rd(logic [15:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // register array model on the memory port
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= ram_rd(mem_addr);
        if (mem_we) ram[mem_addr] = mem_wdata;
    end

    // monitor: pops expected writes and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_re) re_cnt++;
            if (mem_we || mem_re)
                check(!(mem_we && mem_re), "R11 strobes overlap", {mem_we, mem_re}, 2'b00);
            if (mem_we) begin
                wr_cnt++;
                if (exp_q.size() == 0)
                    check(1'b0, "R3/R8/R9/R10 unexpected write", {mem_addr, mem_wdata}, 0);
                else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check({mem_addr, mem_wdata} == e, "R3/R5 write addr/data",
                          {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    task automatic set_hdr(input logic [15:0] a, input logic acc, input logic [14:0] len);
        tx_buf[0] = a[15:8];
        tx_buf[1] = a[7:0];
        tx_buf[2] = {acc, len[14:8]};
        tx_buf[3] = len[7:0];
    endtask

    // R1: bit-level master, mode 3 when m3 is set
    task automatic xfer(input bit m3, input int nbits);
        @(negedge clk);
        sclk = m3;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = tx_buf[i/8][7 - (i%8)];
            repeat (H) @(negedge clk);
            rx_buf[i/8][7 - (i%8)] = miso;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            if (i == 8) check(miso_oe === 1'b1, "R6 oe while selected", miso_oe, 1);
        end
        if (!m3) sclk = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_write(input bit m3, input logic [15:0] a, input int len,
                            input int nsend, input logic [7:0] seed);
        int w0;
        set_hdr(a, 1'b1, 15'(len));
        for (int i = 0; i < nsend; i++) begin
            logic [7:0] d;
            logic [15:0] ai;
            d  = 8'(seed + i * 37);
            ai = 16'(a + i);
            tx_buf[4+i] = d;
            if (i < len) begin
                exp_q.push_back({ai, d});
                ref_mem[ai] = d;
            end
        end
        w0 = wr_cnt;
        xfer(m3, 32 + 8 * nsend);
        check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
        check(wr_cnt - w0 == ((nsend < len) ? nsend : len), "R3/R8/R10 write count",
              wr_cnt - w0, (nsend < len) ? nsend : len);
    endtask

    task automatic do_read(input bit m3, input logic [15:0] a, input int len, input int nsend);
        int r0;
        set_hdr(a, 1'b0, 15'(len));
        for (int i = 0; i < nsend; i++) tx_buf[4+i] = 8'h00;
        r0 = re_cnt;
        xfer(m3, 32 + 8 * nsend);
        check({rx_buf[0], rx_buf[1], rx_buf[2], rx_buf[3]} == 32'h0, "R6 MISO low in header",
              {rx_buf[0], rx_buf[1], rx_buf[2], rx_buf[3]}, 0);
        for (int i = 0; i < nsend; i++) begin
            logic [7:0] e;
            e = (i < len) ? ref_rd(16'(a + i)) : 8'h00;
            check(rx_buf[4+i] == e, (i < len) ? "R4/R5 read data" : "R8 read past count",
                  rx_buf[4+i], e);
        end
        check(re_cnt - r0 == len, "R4/R8/R10 fetch count", re_cnt - r0, len);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(miso_oe === 1'b0 && mem_we === 1'b0 && mem_re === 1'b0,
              "R7 reset outputs", {miso_oe, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        do_write(1'b0, 16'h1234, 1, 1, 8'hA5);     // R2 R3 single write, mode 0
        do_read (1'b0, 16'h1234, 1, 1);            // R4 single read
        do_write(1'b1, 16'h0100, 4, 4, 8'h11);     // R1 R5 burst write, mode 3
        do_read (1'b1, 16'h0100, 4, 4);            // R5 burst read, mode 3
        do_write(1'b0, 16'hFFFE, 3, 3, 8'h70);     // R5 wrap
        do_read (1'b1, 16'hFFFE, 3, 3);
        do_write(1'b1, 16'h0200, 2, 4, 8'hC3);     // R8 extra write bytes
        do_read (1'b0, 16'h0200, 4, 4);            // R8 bytes 2,3 unchanged
        do_read (1'b0, 16'h0200, 1, 3);            // R8 MISO zero past count

        // R9: abort after 4 data bits, then abort mid-header
        begin
            int w0;
            w0 = wr_cnt;
            set_hdr(16'h0300, 1'b1, 15'd1);
            tx_buf[4] = 8'hFF;
            xfer(1'b0, 36);
            set_hdr(16'h0300, 1'b1, 15'd1);
            xfer(1'b1, 10);
            check(wr_cnt == w0, "R9 partial byte not written", wr_cnt - w0, 0);
            check(miso_oe === 1'b0, "R7 oe off when deselected", miso_oe, 0);
        end
        do_read(1'b0, 16'h0300, 1, 1);             // R9 fresh header decoded

        do_write(1'b0, 16'h0400, 0, 1, 8'h99);     // R10 zero count write
        do_read (1'b1, 16'h0400, 0, 1);            // R10 zero count read
        do_read (1'b0, 16'h0400, 1, 1);

        check(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog R1", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule